// File: doc/BRIEF.md
# Transmit Frame Validator and Launcher

This block holds an outgoing Ethernet frame in an internal byte buffer and sends it out on a byte stream once software commits a length. Software first fills the buffer through a plain byte write port. The buffer holds the full line image: seven 0x55 preamble bytes, one 0xD5 start delimiter, the frame itself and a four-byte CRC trailer. Software then writes a nonzero byte count to the length register, and that write starts the launch.

The block first checks that the length lies within the allowed window. It then reads the eight header bytes back and compares them. If any check fails, the frame is dropped: the length register returns to zero, an error flag rises and no interrupt is issued. A frame that passes is streamed from buffer offset 8, without its header and its CRC trailer, on a valid/ready byte interface. After the final byte is accepted, the length register clears and a one-cycle interrupt follows.

Back-pressure rules on the output: a byte is transferred on a rising clock edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values and `tx_valid` stays high. `tx_valid` never depends on `tx_ready`.

Top module: `txframe_launcher`

## Requirements
- R1: After reset, `len_q` is 0 and `tx_valid`, `tx_last`, `tx_irq` and `tx_err` are all low.
- R2: A nonzero write to the length register while the block is idle starts a launch and shows the value on `len_q`. A length write made while a launch is in progress is ignored, and `len_q` keeps the launch length.
- R3: A length above 1530 is rejected: `tx_err` rises, `len_q` returns to 0, no byte is streamed and `tx_irq` stays low.
- R4: A length below 72 is rejected in the same way as in R3.
- R5: The frame is rejected in the same way as in R3 unless buffer bytes 0 to 6 are all 0x55 and byte 7 is 0xD5.
- R6: A valid frame of length N streams exactly N-12 bytes, which are buffer bytes 8 through N-5 in ascending order.
- R7: `tx_last` is high exactly on the final streamed byte.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` and `tx_last` do not change in the next cycle.
- R9: In the cycle after the final byte transfer, `len_q` reads 0 and `tx_irq` is high for exactly one cycle. `tx_err` is cleared when a new nonzero length is accepted, so it stays low after a good launch.
- R10: The boundary lengths 72 and 1530 are both accepted and stream 60 and 1518 bytes.
- R11: Writing a length of zero starts nothing: no byte is streamed, no interrupt is raised and `tx_err` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_we | input | 1 | Buffer byte write enable |
| buf_addr | input | 11 | Buffer byte address |
| buf_wdata | input | 8 | Buffer write data |
| len_we | input | 1 | Length register write strobe |
| len_wdata | input | 12 | Length value to write |
| len_q | output | 12 | Current length register contents |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_irq | output | 1 | One-cycle launch-complete pulse |
| tx_err | output | 1 | Last launch attempt was rejected |

## Verification
Two functions can land in the same cycle: a software length write and the hand-off of the final stream byte, which also clears the register. The bench issues a length write of 100 in exactly the cycle where the last byte meets a high ready, and a second time in the middle of a frame. It then checks that `len_q` reads 0 in the first case and keeps the launch length in the second. In both cases the streamed byte count and the interrupt count must be unchanged and no second launch may follow.

// File: rtl/txl_pkg.sv
package txl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_SEND,
    ST_DONE,
    ST_REJ
  } txl_state_e;

  localparam int HDR_BYTES = 8;
  localparam int CRC_BYTES = 4;
  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  function automatic logic [7:0] hdr_expect(input int unsigned idx);
    return (idx == HDR_BYTES - 1) ? SFD_BYTE : PRE_BYTE;
  endfunction
endpackage

// File: rtl/txl_buf_ram.sv
module txl_buf_ram #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/txl_len_check.sv
module txl_len_check #(
  parameter int CW      = 12,
  parameter int MIN_LEN = 72,
  parameter int MAX_LEN = 1530
) (
  input  logic [CW-1:0] len,
  output logic          ok
);
  localparam logic [CW-1:0] LO = CW'(MIN_LEN);
  localparam logic [CW-1:0] HI = CW'(MAX_LEN);

  always_comb ok = (len >= LO) && (len <= HI);
endmodule

// File: rtl/txl_ctrl.sv
module txl_ctrl
  import txl_pkg::*;
#(
  parameter int AW = 11,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          len_we,
  input  logic [CW-1:0] len_wdata,
  input  logic          len_ok,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] len_q,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  output logic          tx_irq,
  output logic          tx_err
);
  localparam logic [AW-1:0] HDR_END  = AW'(HDR_BYTES - 1);
  localparam logic [CW-1:0] TAIL_OFF = CW'(CRC_BYTES + 1);

  txl_state_e    state;
  logic [AW-1:0] ptr;
  logic [CW-1:0] last_idx;
  logic          xfer;
  logic          hdr_bad;

  always_comb begin
    last_idx = len_q - TAIL_OFF;
    tx_valid = (state == ST_SEND);
    tx_last  = tx_valid && ({{(CW-AW){1'b0}}, ptr} == last_idx);
    xfer     = tx_valid && tx_ready;
    tx_irq   = (state == ST_DONE);
    hdr_bad  = (rdata != hdr_expect(32'(ptr)));
    unique case (state)
      ST_HDR:  raddr = ptr + AW'(1);
      ST_SEND: raddr = xfer ? ptr + AW'(1) : ptr;
      default: raddr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      len_q  <= '0;
      tx_err <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          ptr <= '0;
          if (len_we) begin
            len_q <= len_wdata;
            if (len_wdata != '0) begin
              tx_err <= 1'b0;
              state  <= len_ok ? ST_HDR : ST_REJ;
            end
          end
        end
        ST_HDR: begin
          if (hdr_bad) begin
            state <= ST_REJ;
          end else begin
            ptr <= ptr + AW'(1);
            if (ptr == HDR_END) state <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (xfer) begin
            if (tx_last) begin
              len_q <= '0;
              ptr   <= '0;
              state <= ST_DONE;
            end else begin
              ptr <= ptr + AW'(1);
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        ST_REJ: begin
          len_q  <= '0;
          ptr    <= '0;
          tx_err <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txframe_launcher.sv
module txframe_launcher #(
  parameter int BUF_BYTES = 2048,
  parameter int MIN_LEN   = 72,
  parameter int MAX_LEN   = 1530,
  parameter int AW        = $clog2(BUF_BYTES),
  parameter int CW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  input  logic          len_we,
  input  logic [CW-1:0] len_wdata,
  output logic [CW-1:0] len_q,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_irq,
  output logic          tx_err
);
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          len_ok;

  txl_buf_ram #(.DEPTH(BUF_BYTES), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_addr),
    .wdata (buf_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  txl_len_check #(.CW(CW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_len (
    .len (len_wdata),
    .ok  (len_ok)
  );

  txl_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_we    (len_we),
    .len_wdata (len_wdata),
    .len_ok    (len_ok),
    .rdata     (rd_data),
    .raddr     (rd_addr),
    .len_q     (len_q),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_last   (tx_last),
    .tx_irq    (tx_irq),
    .tx_err    (tx_err)
  );

  assign tx_data = rd_data;
endmodule

// File: rtl/txl_checker.sv
module txl_checker #(
  parameter int CW      = 12,
  parameter int MIN_LEN = 72
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          tx_irq,
  input logic          tx_err,
  input logic [CW-1:0] len_q
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R8
  AST_LAST_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid); // R7
  AST_LAST_THEN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> (tx_irq && len_q == '0)); // R9
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R9
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_err) |-> (!tx_irq && !tx_valid && len_q == '0)); // R3
  AST_SEND_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (len_q >= CW'(MIN_LEN))); // R2
endmodule

bind txframe_launcher txl_checker #(.CW(CW), .MIN_LEN(MIN_LEN)) i_txl_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .tx_last  (tx_last),
  .tx_irq   (tx_irq),
  .tx_err   (tx_err),
  .len_q    (len_q)
);

// File: tb/test_txframe_launcher.sv
module test_txframe_launcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_we = 1'b0;
  logic [10:0] buf_addr = '0;
  logic [7:0]  buf_wdata = '0;
  logic        len_we = 1'b0;
  logic [11:0] len_wdata = '0;
  logic [11:0] len_q;
  logic        tx_valid, tx_ready, tx_last, tx_irq, tx_err;
  logic [7:0]  tx_data;
  logic [7:0]  img [2048];
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  txframe_launcher i_txframe_launcher (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .len_we(len_we), .len_wdata(len_wdata),
    .len_q(len_q), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_irq(tx_irq), .tx_err(tx_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_frame(input int n, input int bad_pos);
    int top;
    for (int i = 0; i < 8; i++) img[i] = (i == 7) ? 8'hD5 : 8'h55;
    if (bad_pos >= 0) img[bad_pos] = img[bad_pos] ^ 8'h01;
    for (int i = 8; i < 2048; i++) img[i] = 8'((i * 7 + n) & 255);
    top = (n > 2048) ? 2048 : ((n < 8) ? 8 : n);
    for (int i = 0; i < top; i++) begin
      @(negedge clk);
      buf_we = 1'b1; buf_addr = 11'(i); buf_wdata = img[i];
    end
    @(negedge clk);
    buf_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input int n, input int rmode, input int coll_idx,
                           input bit exp_ok, input string req);
    int got = 0, irqs = 0, t = 0, tail = 0, exp_len = 0;
    bit done = 0, stall = 0, pend = 0, coll_used = 0;
    logic [7:0] pd;
    logic pl;
    @(negedge clk);
    len_we = 1'b1; len_wdata = 12'(n);
    @(negedge clk);
    len_we = 1'b0;
    #1;
    chk(len_q == 12'(n), "R2 length shown", len_q, n);
    while (tail < 4 && t < 4000) begin
      tx_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (t % 3 != 0) : (t % 5 < 2);
      len_we = 1'b0;
      if (coll_idx >= 0 && !coll_used && tx_valid && got == coll_idx) begin
        len_we = 1'b1; len_wdata = 12'd100; coll_used = 1;
        exp_len = (tx_ready && got == n - 13) ? 0 : n;
      end
      #1;
      if (pend) begin
        chk(len_q == 12'(exp_len), "R2 write during launch ignored", len_q, exp_len);
        pend = 0;
      end
      if (len_we) pend = 1;
      if (stall) begin
        chk(tx_valid == 1'b1, "R8 valid held", tx_valid, 1);
        chk(tx_data == pd && tx_last == pl, "R8 data held", tx_data, pd);
      end
      if (tx_valid) begin
        if (!exp_ok) chk(0, {req, " stream on reject"}, got, 0);
        else if (got < n - 12) begin
          if (tx_data !== img[8 + got])
            chk(0, "R6 byte value", tx_data, img[8 + got]);
          if (tx_last !== (got == n - 13))
            chk(0, "R7 last flag", tx_last, got == n - 13);
        end
        if (tx_ready) got++;
      end
      stall = tx_valid && !tx_ready;
      pd = tx_data; pl = tx_last;
      if (tx_irq) irqs++;
      if (tx_irq || tx_err) done = 1;
      if (done) tail++;
      @(negedge clk);
      t++;
    end
    len_we = 1'b0; tx_ready = 1'b1;
    chk(t < 4000, {req, " completion"}, t, 4000);
    chk(len_q == 0, {req, " length cleared"}, len_q, 0);
    if (exp_ok) begin
      chk(got == n - 12, {req, " R6 byte count"}, got, n - 12);
      chk(irqs == 1, "R9 single interrupt", irqs, 1);
      chk(tx_err == 1'b0, "R9 error clear", tx_err, 0);
    end else begin
      chk(got == 0, {req, " no bytes"}, got, 0);
      chk(irqs == 0, {req, " no interrupt"}, irqs, 0);
      chk(tx_err == 1'b1, {req, " error flag"}, tx_err, 1);
    end
  endtask

  task automatic test_reset();
    #1;
    chk(len_q == 0 && !tx_valid && !tx_last && !tx_irq && !tx_err,
        "R1 reset state", {len_q, tx_valid, tx_irq, tx_err}, 0);
  endtask

  task automatic test_zero_len();
    bit seen = 0;
    bit err0 = tx_err;
    @(negedge clk);
    len_we = 1'b1; len_wdata = 12'd0;
    @(negedge clk);
    len_we = 1'b0;
    for (int i = 0; i < 30; i++) begin
      #1;
      if (tx_valid || tx_irq) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R11 zero length starts nothing", seen, 0);
    chk(tx_err == err0 && len_q == 0, "R11 state unchanged", tx_err, err0);
  endtask

  initial begin
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    load_frame(100, -1);  run_frame(100, 0, -1, 1, "R6 basic");
    load_frame(90, -1);   run_frame(90, 1, -1, 1, "R8 stalls");
    load_frame(1531, -1); run_frame(1531, 0, -1, 0, "R3 too long");
    load_frame(72, -1);   run_frame(72, 2, -1, 1, "R10 min length");
    load_frame(71, -1);   run_frame(71, 0, -1, 0, "R4 too short");
    load_frame(120, 7);   run_frame(120, 0, -1, 0, "R5 bad delimiter");
    load_frame(120, 3);   run_frame(120, 0, -1, 0, "R5 bad preamble");
    test_zero_len();
    load_frame(1530, -1); run_frame(1530, 2, -1, 1, "R10 max length");
    load_frame(110, -1);  run_frame(110, 1, 5, 1, "R2 mid collision");
    load_frame(80, -1);   run_frame(80, 0, 67, 1, "R2 final collision");
    test_zero_len();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule